// File: doc/BRIEF.md
# Byte-Wide EPROM Pulse-Verify Programming Sequencer

This controller burns a data image into a UV-erasable, byte-wide memory device. After a start request it steps through every address from zero upward. For each byte it first reads the location back. A byte that already holds the image value needs no pulse. A byte whose image would need a zero to become a one again cannot be programmed, and the run stops with a failure. Any other byte gets fixed-width program pulses, each followed by a read-back, until the byte matches or a pulse limit is reached.

While these per-byte pulses run, a raised-supply strobe and a programming-voltage strobe stay asserted. When the last address is done, both strobes drop. A closing pass then reads every location in normal read mode and compares it with the image again. The analog supplies are outside the block: it drives only the strobes that an external supply circuit acts on.

The image comes from a source port. That port must return the byte for `src_addr` within the same clock cycle. Pulse width, read settle time and pulse limit are parameters. At the default 125 MHz clock, the default pulse width of 12500 cycles gives 100 us.

Top module: `eprom_pgm_seq`

## Requirements
- R1: A program pulse drives `dev_ce_n` low for exactly PULSE_CYC clock cycles. During the pulse, `dev_oe_n` is high, `vpp_en` and `vcc_hi` are high, and `dev_wdata` equals the image byte for `dev_addr`.
- R2: Each pulse is followed by a read-back with `dev_oe_n` low, `dev_ce_n` high and `vpp_en` high. A read-back that matches ends the pulsing for that address, so a byte needing k pulses receives exactly k.
- R3: An address never receives more than MAX_PULSES pulses. If the byte still mismatches after the last allowed pulse, the run ends with `done` and `fail` high, and `fail_addr` holds that address.
- R4: Before any pulse, the current byte is read. If the image has a one where the device holds a zero, the run ends with `fail` high and `fail_addr` set to that address, and no pulse is given there.
- R5: A byte that already matches the image receives no pulse.
- R6: Addresses are handled in ascending order, starting at 0 and ending at 2^ADDR_W-1. Pulses never go to a lower address than an earlier pulse of the same run.
- R7: `vcc_hi` and `vpp_en` stay high throughout the pulse phase. During the closing pass they are low, and each location is read with `dev_ce_n` and `dev_oe_n` both low for READ_CYC cycles.
- R8: A mismatch in the closing pass ends the run with `fail` high and `fail_addr` set to the mismatching address.
- R9: `start` is accepted only while the block is not busy. `done`, together with `fail` and `fail_addr`, holds until the next `start`. A `start` during a run has no effect.
- R10: After reset, `busy`, `done`, `fail`, `vpp_en` and `vcc_hi` are low, and `dev_ce_n` and `dev_oe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Finished run failed |
| fail_addr | output | ADDR_W | Address of the failure |
| src_addr | output | ADDR_W | Image read address |
| src_data | input | DATA_W | Image byte for src_addr, same cycle |
| dev_addr | output | ADDR_W | Device address |
| dev_wdata | output | DATA_W | Byte driven to the device during a pulse |
| dev_rdata | input | DATA_W | Byte read from the device |
| dev_oe_n | output | 1 | Device output enable, active low |
| dev_ce_n | output | 1 | Device chip enable / program strobe, active low |
| vpp_en | output | 1 | Programming-voltage control |
| vcc_hi | output | 1 | Raised-supply control |

## Verification
The assertions check several rules on every cycle: the strobe combination during a pulse, the exact pulse length, the per-address pulse cap, strobes off during normal-mode reads, ascending addresses, and an idle output state once a run ends. Other behaviours depend on a device that responds slowly or wrongly, and only the bench's scenarios can show them. These include the exact count of pulses per byte, the refusal of a one-restoring byte, the skipping of bytes that already match, and a cell that reads correctly at raised supply but fails at nominal supply.

// File: rtl/eps_pkg.sv
// Shared types for the EPROM programming sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package eps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_PRECHK = 3'd2,
        ST_PULSE  = 3'd3,
        ST_VERIFY = 3'd4,
        ST_FREAD  = 3'd5,
        ST_ADV    = 3'd6,
        ST_END    = 3'd7
    } seq_state_t;

endpackage

// File: rtl/eps_timer.sv
// Down-counting interval timer. Loading N-1 makes `expired` rise
// after N cycles in the loaded state.
// Assumes: load and count do not conflict (load wins).
module eps_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Reload on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/eps_byte_cmp.sv
// Compares a byte read back from the device with the target byte.
// `blocked` flags bits that would need a 0 -> 1 change, which
// programming cannot do.
// Assumes: an erased bit reads as one.
module eps_byte_cmp #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rd,
    input  logic [DW-1:0] tgt,
    output logic          match,
    output logic          blocked
);
    // Purely combinational compare.
    always_comb begin
        match   = (rd == tgt);
        blocked = |(tgt & ~rd);
    end
endmodule

// File: rtl/eprom_pgm_seq.sv
// Pulse-and-verify EPROM programming sequencer.
// Walks addresses upward. Each byte is prechecked, then pulsed and
// read back until it matches or the pulse cap is hit. A closing
// read pass runs at nominal supply.
// Assumes: src_data is valid in the same cycle as src_addr, and
// dev_rdata is valid READ_CYC cycles after a read strobe begins.
module eprom_pgm_seq #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 12500,
    parameter int READ_CYC   = 2,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_oe_n,
    output logic              dev_ce_n,
    output logic              vpp_en,
    output logic              vcc_hi
);
    import eps_pkg::*;

    localparam int LONGEST = (PULSE_CYC > READ_CYC) ? PULSE_CYC : READ_CYC;
    localparam int TMR_W   = $clog2(LONGEST) + 1;
    localparam int PC_W    = $clog2(MAX_PULSES + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [TMR_W-1:0]  PULSE_LD  = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0]  READ_LD   = TMR_W'(READ_CYC - 1);
    localparam logic [PC_W-1:0]   PC_MAX    = PC_W'(MAX_PULSES);

    seq_state_t        st;
    logic              final_pass;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] tgt;
    logic [PC_W-1:0]   pcnt;
    logic              fail_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              byte_ok;
    logic              byte_blocked;

    eps_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    eps_byte_cmp #(.DW(DATA_W)) u_cmp (
        .rd      (dev_rdata),
        .tgt     (tgt),
        .match   (byte_ok),
        .blocked (byte_blocked)
    );

    // Choose when the timer restarts and with which interval.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = READ_LD;
        unique case (st)
            ST_FETCH:  tmr_load = 1'b1;
            ST_PRECHK: if (tmr_exp && !byte_blocked && !byte_ok) begin
                           tmr_load = 1'b1;
                           tmr_val  = PULSE_LD;
                       end
            ST_PULSE:  tmr_load = tmr_exp;
            ST_VERIFY: if (tmr_exp && !byte_ok && pcnt < PC_MAX) begin
                           tmr_load = 1'b1;
                           tmr_val  = PULSE_LD;
                       end
            default:   tmr_load = 1'b0;
        endcase
    end

    // Main sequencer: address walk, pulse count and failure capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            final_pass  <= 1'b0;
            addr        <= '0;
            tgt         <= '1;
            pcnt        <= '0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_END: if (start) begin
                    st         <= ST_FETCH;
                    final_pass <= 1'b0;
                    addr       <= '0;
                    fail_q     <= 1'b0;
                end
                ST_FETCH: begin
                    tgt <= src_data;
                    st  <= final_pass ? ST_FREAD : ST_PRECHK;
                end
                ST_PRECHK: if (tmr_exp) begin
                    if (byte_blocked) begin
                        fail_q      <= 1'b1;
                        fail_addr_q <= addr;
                        st          <= ST_END;
                    end else if (byte_ok) begin
                        st <= ST_ADV;
                    end else begin
                        pcnt <= '0;
                        st   <= ST_PULSE;
                    end
                end
                ST_PULSE: if (tmr_exp) begin
                    pcnt <= pcnt + 1'b1;
                    st   <= ST_VERIFY;
                end
                ST_VERIFY: if (tmr_exp) begin
                    if (byte_ok) begin
                        st <= ST_ADV;
                    end else if (pcnt >= PC_MAX) begin
                        fail_q      <= 1'b1;
                        fail_addr_q <= addr;
                        st          <= ST_END;
                    end else begin
                        st <= ST_PULSE;
                    end
                end
                ST_FREAD: if (tmr_exp) begin
                    if (!byte_ok) begin
                        fail_q      <= 1'b1;
                        fail_addr_q <= addr;
                        st          <= ST_END;
                    end else begin
                        st <= ST_ADV;
                    end
                end
                ST_ADV: begin
                    if (addr == LAST_ADDR) begin
                        if (!final_pass) begin
                            final_pass <= 1'b1;
                            addr       <= '0;
                            st         <= ST_FETCH;
                        end else begin
                            st <= ST_END;
                        end
                    end else begin
                        addr <= addr + 1'b1;
                        st   <= ST_FETCH;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Decode device strobes and handshake outputs from the state.
    always_comb begin
        busy      = (st != ST_IDLE) && (st != ST_END);
        done      = (st == ST_END);
        fail      = fail_q;
        fail_addr = fail_addr_q;
        vcc_hi    = busy && !final_pass;
        vpp_en    = busy && !final_pass;
        dev_ce_n  = !((st == ST_PULSE) || (st == ST_FREAD));
        dev_oe_n  = !((st == ST_PRECHK) || (st == ST_VERIFY) || (st == ST_FREAD));
        dev_addr  = addr;
        src_addr  = addr;
        dev_wdata = tgt;
    end

    // ---------------- assertions ----------------
    logic [TMR_W-1:0] chk_low;

    // Checker counter: length of the current chip-enable low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)         chk_low <= '0;
        else if (!dev_ce_n) chk_low <= chk_low + 1'b1;
        else                chk_low <= '0;
    end

    p_pulse_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && vpp_en) |-> (dev_oe_n && vcc_hi));

    p_pulse_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dev_ce_n) && $past(vpp_en)) |-> ($past(chk_low) == TMR_W'(PULSE_CYC - 1)));

    p_pulse_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pcnt <= PC_MAX));

    p_nominal_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_ce_n && !dev_oe_n) |-> (!vcc_hi && !vpp_en));

    p_addr_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_hi && $past(vcc_hi)) |-> (dev_addr >= $past(dev_addr)));

    p_end_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !vcc_hi && !vpp_en && dev_ce_n && dev_oe_n));

endmodule

// File: tb/eprom_pgm_seq_bench.sv
module eprom_pgm_seq_bench;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int NADDR = 1 << AW;
    localparam int PW    = 4;
    localparam int RC    = 2;
    localparam int MAXP  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr, src_addr, dev_addr;
    logic [DW-1:0] src_data, dev_wdata, dev_rdata;
    logic          dev_oe_n, dev_ce_n, vpp_en, vcc_hi;

    logic [DW-1:0] mem [NADDR];
    logic [DW-1:0] img [NADDR];
    int            need [NADDR];
    int            pcount [NADDR];
    logic          weak_en = 1'b0;
    logic [AW-1:0] weak_a = '0;

    int cyc = 0, total = 0, bad = 0;
    int low_cnt = 0, bad_width = 0, bad_ctl = 0, bad_order = 0;
    int bad_final = 0, fread = 0, pulses = 0, last_pa = -1;
    logic prev_ce_n = 1'b1, prev_vpp = 1'b0;

    always #4 clk = ~clk;

    eprom_pgm_seq #(
        .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PW), .READ_CYC(RC), .MAX_PULSES(MAXP)
    ) u_eprom_pgm_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .src_addr(src_addr), .src_data(src_data),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_oe_n(dev_oe_n), .dev_ce_n(dev_ce_n), .vpp_en(vpp_en), .vcc_hi(vcc_hi)
    );

    assign src_data  = img[src_addr];
    assign dev_rdata = dev_oe_n ? 8'h00 :
                       ((weak_en && dev_addr == weak_a && !vcc_hi) ? (mem[dev_addr] ^ 8'h01)
                                                                   : mem[dev_addr]);

    // Device model and protocol monitor, sampled away from the clock edge.
    always @(negedge clk) begin
        cyc++;
        if (prev_ce_n && !dev_ce_n && vpp_en) begin
            if (!dev_oe_n || !vcc_hi || dev_wdata !== img[dev_addr]) bad_ctl++;
            if (int'(dev_addr) < last_pa) bad_order++;
            last_pa = int'(dev_addr);
            pcount[dev_addr]++;
            pulses++;
            if (pcount[dev_addr] >= need[dev_addr]) mem[dev_addr] = mem[dev_addr] & dev_wdata;
        end
        if (dev_ce_n) begin
            if (!prev_ce_n && prev_vpp && low_cnt != PW) bad_width++;
            low_cnt = 0;
        end else begin
            low_cnt++;
        end
        if (!dev_ce_n && !dev_oe_n) begin
            fread++;
            if (vcc_hi || vpp_en) bad_final++;
        end
        prev_ce_n = dev_ce_n;
        prev_vpp  = vpp_en;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic dev_init();
        for (int i = 0; i < NADDR; i++) begin
            mem[i] = 8'hFF; need[i] = 1; pcount[i] = 0;
            img[i] = DW'((i * 37) ^ 8'h5A);
        end
        weak_en = 1'b0;
        bad_width = 0; bad_ctl = 0; bad_order = 0; bad_final = 0;
        fread = 0; pulses = 0; last_pa = -1;
    endtask

    task automatic run_seq(input bit poke_mid);
        int t;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (poke_mid && t == 40) start = 1'b1;
            if (poke_mid && t == 41) start = 1'b0;
        end
        check(done === 1'b1 && busy === 1'b0, "R9 run finished", int'(done), 1);
    endtask

    function automatic int count_mismatch();
        int n = 0;
        for (int i = 0; i < NADDR; i++) if (mem[i] !== img[i]) n++;
        return n;
    endfunction

    task automatic t_reset();
        check(!busy && !done && !fail, "R10 handshake idle", int'({busy, done, fail}), 0);
        check(dev_ce_n && dev_oe_n && !vpp_en && !vcc_hi, "R10 strobes idle",
              int'({dev_ce_n, dev_oe_n, vpp_en, vcc_hi}), 12);
    endtask

    task automatic t_basic();
        int want;
        dev_init();
        want = 0;
        for (int i = 0; i < NADDR; i++) if (img[i] != 8'hFF) want++;
        run_seq(1'b0);
        check(!fail, "R7 basic no fail", int'(fail), 0);
        check(count_mismatch() == 0, "R2 image programmed", count_mismatch(), 0);
        check(pulses == want, "R5 one pulse per differing byte", pulses, want);
        check(bad_width == 0, "R1 pulse width", bad_width, 0);
        check(bad_ctl == 0, "R1 pulse strobes and data", bad_ctl, 0);
        check(bad_order == 0, "R6 ascending addresses", bad_order, 0);
        check(fread == NADDR * RC, "R7 closing pass reads", fread, NADDR * RC);
        check(bad_final == 0, "R7 nominal supply in closing pass", bad_final, 0);
        repeat (20) @(negedge clk);
        check(done && !busy, "R9 done holds", int'(done), 1);
    endtask

    task automatic t_multi();
        int want;
        dev_init();
        want = 0;
        for (int i = 0; i < NADDR; i++) begin
            need[i] = 1 + (i % 4);
            if (img[i] != 8'hFF) want += need[i];
        end
        run_seq(1'b0);
        check(!fail, "R3 multi-pulse success", int'(fail), 0);
        check(pulses == want, "R2 pulses equal needed count", pulses, want);
        check(pcount[2] == 3, "R2 address 2 pulses", pcount[2], 3);
        check(bad_width == 0 && bad_order == 0, "R1 multi-pulse form", bad_width + bad_order, 0);
    endtask

    task automatic t_limit();
        dev_init();
        need[5] = MAXP + 1;
        run_seq(1'b0);
        check(fail === 1'b1, "R3 limit fail", int'(fail), 1);
        check(fail_addr == 4'd5, "R3 limit fail_addr", int'(fail_addr), 5);
        check(pcount[5] == MAXP, "R3 pulse cap", pcount[5], MAXP);
        check(pcount[6] == 0 && mem[6] == 8'hFF, "R3 later address untouched", pcount[6], 0);
    endtask

    task automatic t_illegal();
        dev_init();
        mem[3] = 8'h0F;
        img[3] = 8'hF0;
        run_seq(1'b0);
        check(fail === 1'b1, "R4 blocked byte fails", int'(fail), 1);
        check(fail_addr == 4'd3, "R4 fail_addr", int'(fail_addr), 3);
        check(pcount[3] == 0, "R4 no pulse on blocked byte", pcount[3], 0);
        check(mem[2] == img[2], "R4 earlier byte programmed", int'(mem[2]), int'(img[2]));
    endtask

    task automatic t_skip();
        dev_init();
        for (int i = 0; i < NADDR; i++) img[i] = 8'hFF;
        img[9] = 8'hA5;
        mem[12] = 8'h3C;
        img[12] = 8'h3C;
        run_seq(1'b0);
        check(!fail, "R5 skip run success", int'(fail), 0);
        check(pulses == 1, "R5 only one byte pulsed", pulses, 1);
        check(pcount[12] == 0, "R5 matching programmed byte skipped", pcount[12], 0);
    endtask

    task automatic t_final();
        dev_init();
        weak_en = 1'b1;
        weak_a  = 4'd7;
        run_seq(1'b0);
        check(fail === 1'b1, "R8 closing pass fail", int'(fail), 1);
        check(fail_addr == 4'd7, "R8 fail_addr", int'(fail_addr), 7);
        check(fread == 8 * RC, "R8 closing reads up to failure", fread, 8 * RC);
    endtask

    task automatic t_busy_start();
        int want;
        dev_init();
        want = 0;
        for (int i = 0; i < NADDR; i++) if (img[i] != 8'hFF) want++;
        run_seq(1'b1);
        check(!fail, "R9 start during run ignored", int'(fail), 0);
        check(pulses == want, "R9 no restart pulses", pulses, want);
        check(bad_order == 0, "R9 order kept", bad_order, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_multi();
        t_limit();
        t_illegal();
        t_skip();
        t_final();
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        wait (cyc > 190000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule